// File: doc/BRIEF.md
# Registered Mixed-Sign Integer Multiplier

This block multiplies two 16-bit operands and presents a 32-bit result on two 16-bit output ports. Each operand sits in its own input register with an active-low load enable, and each carries a mode bit that picks two's complement or unsigned interpretation. Signed, unsigned and mixed-sign products are therefore all available from one array. A rounding request is registered alongside the operands. When it is set, a constant is added at the top bit position that the selected output format discards. Dropping the low half then leaves a result rounded to 16 bits.

A format stage offers two layouts. The first is the plain 32-bit product. The second is a left-aligned 31-bit layout, in which the upper half holds product bits 30..15 and the sign is copied into the top bit of the low half. Two result registers hold the formatted halves. They have a shared active-low load enable and a pass-through mode that makes them transparent. The upper output port can show either half. Both ports have active-low output enables, and a deasserted enable puts its port in high impedance. The top bit of the result is also given as a separate pair of outputs, one true and one inverted. In registered mode a product appears at the ports after two rising edges. In pass-through mode it appears after one. There is no reset.

Top module: `opMultiplier`

## Requirements
- R1: When `enaN` is low at a rising edge, `aIn` and `tcaIn` are captured. When it is high, the captured operand A and its mode stay unchanged.
- R2: When `enbN` is low at a rising edge, `bIn` and `tcbIn` are captured. When it is high, the captured operand B and its mode stay unchanged.
- R3: A mode bit of 1 treats its operand as two's complement, and a mode bit of 0 treats it as unsigned. The two operands are chosen independently. The result is the low 32 bits of the exact product.
- R4: `rndIn` is captured at a rising edge only when `enaN` or `enbN` is low. When both are high, a change on `rndIn` has no effect on the result.
- R5: A captured round bit of 1 adds 2^15 to the product when `rsIn` is 1 and adds 2^14 when `rsIn` is 0, before formatting. The sum wraps modulo 2^32.
- R6: With `rsIn` = 1, the upper result half is sum bits 31..16 and the lower half is sum bits 15..0.
- R7: With `rsIn` = 0, the upper result half is sum bits 30..15. The lower half is sum bit 31 followed by sum bits 14..0.
- R8: The result registers load the formatted value at a rising edge when `enrN` is low and hold it when `enrN` is high. With `ftIn` = 0, a product shows at the outputs after the second rising edge counted from operand capture.
- R9: With `ftIn` = 1 and `enrN` low, the outputs follow the formatted value without waiting for a clock edge. With `enrN` high, the outputs show the held register value whatever `ftIn` is.
- R10: `yLo` carries the lower result half. `yHi` carries the upper half when `selLo` = 0 and the lower half when `selLo` = 1.
- R11: `msbT` equals bit 15 of the upper result half, and `msbN` is its inverse.
- R12: `oeHiN` = 1 releases `yHi` to high impedance and `oeLoN` = 1 releases `yLo`. A value of 0 drives the port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| aIn | input | 16 | Operand A |
| bIn | input | 16 | Operand B |
| tcaIn | input | 1 | Mode of A: 1 signed, 0 unsigned |
| tcbIn | input | 1 | Mode of B: 1 signed, 0 unsigned |
| enaN | input | 1 | Active-low load of A register |
| enbN | input | 1 | Active-low load of B register |
| rndIn | input | 1 | Round request |
| rsIn | input | 1 | Format: 1 full 32-bit, 0 left-aligned 31-bit |
| enrN | input | 1 | Active-low load of result registers |
| ftIn | input | 1 | Pass-through of result registers |
| selLo | input | 1 | Upper port shows lower half when 1 |
| oeHiN | input | 1 | Active-low output enable of yHi |
| oeLoN | input | 1 | Active-low output enable of yLo |
| yHi | output | 16 | Upper output port |
| yLo | output | 16 | Lower output port |
| msbT | output | 1 | Result top bit, true |
| msbN | output | 1 | Result top bit, inverted |

## Verification
The bench builds the block at its default operand width of 16. At that width, the extreme operands 0x7FFF, 0x8000 and 0xFFFF under every pairing of mode bits reach both ends of the product range, and the round constant lands exactly on the format boundaries. A reference model in the bench computes the exact product with wide signed arithmetic, then applies rounding and both layouts itself. Directed sequences cover the enable hold cases, the two-edge and one-edge latencies, pass-through, port selection and release of the ports.

// File: rtl/opMulPkg.sv
package opMulPkg;

  // Strobes from the control decode to the datapath.
  typedef struct packed {
    logic capA;     // load operand A and its mode
    logic capB;     // load operand B and its mode
    logic capRnd;   // load round request
    logic capRes;   // load result registers
    logic passRes;  // result registers transparent
  } mulStrobe_t;

endpackage

// File: rtl/opMulCtrl.sv
module opMulCtrl
  import opMulPkg::*;
(
  input  logic       enaN,
  input  logic       enbN,
  input  logic       enrN,
  input  logic       ftIn,
  output mulStrobe_t strobe
);

  always_comb begin
    strobe.capA    = ~enaN;
    strobe.capB    = ~enbN;
    strobe.capRnd  = ~enaN | ~enbN;
    strobe.capRes  = ~enrN;
    strobe.passRes = ftIn & ~enrN;
  end

endmodule

// File: rtl/opMulPath.sv
module opMulPath
  import opMulPkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  mulStrobe_t   strobe,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic         tcaIn,
  input  logic         tcbIn,
  input  logic         rndIn,
  input  logic         rsIn,
  output logic [W-1:0] viewHi,
  output logic [W-1:0] viewLo
);

  localparam int PW = 2 * W;
  localparam int XW = W + 1;

  logic [W-1:0]  aReg, bReg;
  logic          tcaReg, tcbReg, rndReg;
  logic [W-1:0]  resHiReg, resLoReg;
  logic [W-1:0]  fmtHi, fmtLo;
  logic signed [XW-1:0]   aExt, bExt;
  logic signed [2*XW-1:0] prodFull;
  logic [PW-1:0] roundK, sumP;

  // Operand and round capture
  always_ff @(posedge clk) begin
    if (strobe.capA) begin
      aReg   <= aIn;
      tcaReg <= tcaIn;
    end
    if (strobe.capB) begin
      bReg   <= bIn;
      tcbReg <= tcbIn;
    end
    if (strobe.capRnd) rndReg <= rndIn;
  end

  // Mixed-sign product: extend each operand by one bit according to its mode
  assign aExt     = $signed({tcaReg & aReg[W-1], aReg});
  assign bExt     = $signed({tcbReg & bReg[W-1], bReg});
  assign prodFull = aExt * bExt;

  // Round constant sits on the top bit the chosen format drops
  assign roundK = rndReg ? (PW'(1) << (rsIn ? W - 1 : W - 2)) : '0;
  assign sumP   = prodFull[PW-1:0] + roundK;

  // Format adjust
  always_comb begin
    if (rsIn) begin
      fmtHi = sumP[PW-1:W];
      fmtLo = sumP[W-1:0];
    end else begin
      fmtHi = sumP[PW-2:W-1];
      fmtLo = {sumP[PW-1], sumP[W-2:0]};
    end
  end

  // Result registers
  always_ff @(posedge clk) begin
    if (strobe.capRes) begin
      resHiReg <= fmtHi;
      resLoReg <= fmtLo;
    end
  end

  assign viewHi = strobe.passRes ? fmtHi : resHiReg;
  assign viewLo = strobe.passRes ? fmtLo : resLoReg;

  // R1: operand A register holds or loads per its enable
  p_hold_a_r1: assert property (@(posedge clk)
    !strobe.capA |=> ($stable(aReg) && $stable(tcaReg)));
  p_load_a_r1: assert property (@(posedge clk)
    strobe.capA |=> (aReg == $past(aIn) && tcaReg == $past(tcaIn)));

  // R2: operand B register holds per its enable
  p_hold_b_r2: assert property (@(posedge clk)
    !strobe.capB |=> ($stable(bReg) && $stable(tcbReg)));

  // R4: round request frozen while both operand enables are high
  p_rnd_hold_r4: assert property (@(posedge clk)
    (!strobe.capA && !strobe.capB) |=> $stable(rndReg));

  // R8: result registers hold or take the formatted value
  p_res_hold_r8: assert property (@(posedge clk)
    !strobe.capRes |=> ($stable(resHiReg) && $stable(resLoReg)));
  p_res_load_r8: assert property (@(posedge clk)
    strobe.capRes |=> (resHiReg == $past(fmtHi) && resLoReg == $past(fmtLo)));

endmodule

// File: rtl/opMultiplier.sv
module opMultiplier
  import opMulPkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic [W-1:0] aIn,
  input  logic [W-1:0] bIn,
  input  logic         tcaIn,
  input  logic         tcbIn,
  input  logic         enaN,
  input  logic         enbN,
  input  logic         rndIn,
  input  logic         rsIn,
  input  logic         enrN,
  input  logic         ftIn,
  input  logic         selLo,
  input  logic         oeHiN,
  input  logic         oeLoN,
  output logic [W-1:0] yHi,
  output logic [W-1:0] yLo,
  output logic         msbT,
  output logic         msbN
);

  mulStrobe_t   strobe;
  logic [W-1:0] viewHi, viewLo, portHi;

  opMulCtrl u_ctrl (
    .enaN   (enaN),
    .enbN   (enbN),
    .enrN   (enrN),
    .ftIn   (ftIn),
    .strobe (strobe)
  );

  opMulPath #(.W(W)) u_path (
    .clk    (clk),
    .strobe (strobe),
    .aIn    (aIn),
    .bIn    (bIn),
    .tcaIn  (tcaIn),
    .tcbIn  (tcbIn),
    .rndIn  (rndIn),
    .rsIn   (rsIn),
    .viewHi (viewHi),
    .viewLo (viewLo)
  );

  // Half-select on the upper port
  assign portHi = selLo ? viewLo : viewHi;

  assign yHi  = oeHiN ? 'z : portHi;
  assign yLo  = oeLoN ? 'z : viewLo;
  assign msbT = viewHi[W-1];
  assign msbN = ~viewHi[W-1];

endmodule

// File: tb/opMultiplier_bench.sv
`timescale 1ns/1ps
module opMultiplier_bench;

  logic        clk = 1'b0;
  logic [15:0] aIn = '0, bIn = '0;
  logic        tcaIn = 0, tcbIn = 0, enaN = 0, enbN = 0, rndIn = 0, rsIn = 1;
  logic        enrN = 0, ftIn = 0, selLo = 0, oeHiN = 0, oeLoN = 0;
  logic [15:0] yHi, yLo;
  logic        msbT, msbN;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  opMultiplier u_opMultiplier (
    .clk(clk), .aIn(aIn), .bIn(bIn), .tcaIn(tcaIn), .tcbIn(tcbIn),
    .enaN(enaN), .enbN(enbN), .rndIn(rndIn), .rsIn(rsIn), .enrN(enrN),
    .ftIn(ftIn), .selLo(selLo), .oeHiN(oeHiN), .oeLoN(oeLoN),
    .yHi(yHi), .yLo(yLo), .msbT(msbT), .msbN(msbN)
  );

  // Stimulus: {a, b, tca, tcb, rnd, rs}
  localparam logic [35:0] VEC [14] = '{
    {16'h0003, 16'h0005, 1'b0, 1'b0, 1'b0, 1'b1},
    {16'hFFFF, 16'hFFFF, 1'b0, 1'b0, 1'b0, 1'b1},
    {16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 1'b0, 1'b1},
    {16'hFFFF, 16'hFFFF, 1'b1, 1'b0, 1'b0, 1'b1},
    {16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 1'b0, 0'b0 + 1'b0},
    {16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b1},
    {16'h8000, 16'h8000, 1'b1, 1'b1, 1'b0, 1'b0},
    {16'h7FFF, 16'h7FFF, 1'b1, 1'b1, 1'b1, 1'b1},
    {16'h7FFF, 16'h7FFF, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'h8000, 16'h7FFF, 1'b1, 1'b1, 1'b1, 1'b0},
    {16'h8000, 16'h0003, 1'b0, 1'b1, 1'b0, 1'b1},
    {16'h1234, 16'hABCD, 1'b1, 1'b0, 1'b1, 1'b1},
    {16'h00FF, 16'h8001, 1'b0, 1'b1, 1'b1, 1'b0},
    {16'hC000, 16'h4000, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  // Reference: exact product, round, then format; returns {hi, lo}
  function automatic logic [31:0] refFmt(input logic [15:0] a, input logic [15:0] b,
                                         input logic tca, input logic tcb,
                                         input logic rnd, input logic rs);
    longint sa, sb, p;
    logic [31:0] q;
    sa = tca ? longint'($signed(a)) : longint'(a);
    sb = tcb ? longint'($signed(b)) : longint'(b);
    p  = sa * sb;
    if (rnd) p = p + (rs ? 64'sd32768 : 64'sd16384);
    q = p[31:0];
    return rs ? q : {q[30:15], q[31], q[14:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkReleased(input string tag, input logic [15:0] act, input logic [15:0] driven);
    checks++;
    if (act === driven) begin
      errors++;
      $display("FAIL %s: actual %h expected released (not %h)", tag, act, driven);
    end
  endtask

  // Check all result outputs against {hi, lo}
  task automatic checkOut(input string tag, input logic [31:0] e);
    check({tag, " R10 yHi/yLo"}, {yHi, yLo}, e);
    check({tag, " R11 msb"}, {30'd0, msbT, msbN}, {30'd0, e[31], ~e[31]});
  endtask

  // Load both operands and round, wait two edges with result loading
  task automatic runOp(input logic [15:0] a, input logic [15:0] b, input logic tca,
                       input logic tcb, input logic rnd, input logic rs);
    @(negedge clk);
    aIn = a; bIn = b; tcaIn = tca; tcbIn = tcb; rndIn = rnd; rsIn = rs;
    enaN = 0; enbN = 0; enrN = 0; ftIn = 0; selLo = 0;
    @(posedge clk);
    @(negedge clk);
    enaN = 1; enbN = 1;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic [31:0] e;
    // Table walk: R3 signedness, R5 rounding, R6/R7 formats, R10 mux, R11 msb
    for (int i = 0; i < 14; i++) begin
      runOp(VEC[i][35:20], VEC[i][19:4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
      e = refFmt(VEC[i][35:20], VEC[i][19:4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0]);
      checkOut($sformatf("vec%0d R3 R5 R6 R7", i), e);
      selLo = 1; #1;
      check($sformatf("vec%0d R10 selLo", i), {16'd0, yHi}, {16'd0, e[15:0]});
      selLo = 0;
    end

    // R1: A held while enaN high, B loads
    runOp(16'd3, 16'd5, 0, 0, 0, 1);
    @(negedge clk); aIn = 16'd100; bIn = 16'd7; enaN = 1; enbN = 0;
    @(posedge clk); @(negedge clk); enbN = 1;
    @(posedge clk); @(negedge clk);
    checkOut("R1 hold A", refFmt(16'd3, 16'd7, 0, 0, 0, 1));

    // R2: B held while enbN high, A loads
    aIn = 16'd9; bIn = 16'd999; enaN = 0; enbN = 1;
    @(posedge clk); @(negedge clk); enaN = 1;
    @(posedge clk); @(negedge clk);
    checkOut("R2 hold B", refFmt(16'd9, 16'd7, 0, 0, 0, 1));

    // R4: round ignored while both enables high
    rndIn = 1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    checkOut("R4 rnd ignored", refFmt(16'd9, 16'd7, 0, 0, 0, 1));
    // R4: round captured with only enbN low
    enbN = 0; bIn = 16'd7;
    @(posedge clk); @(negedge clk); enbN = 1;
    @(posedge clk); @(negedge clk);
    checkOut("R4 R5 rnd via B", refFmt(16'd9, 16'd7, 0, 0, 1, 1));
    // R5/R7: round position follows rsIn
    rsIn = 0;
    @(posedge clk); @(negedge clk);
    checkOut("R5 R7 rnd rs0", refFmt(16'd9, 16'd7, 0, 0, 1, 0));
    rsIn = 1; rndIn = 0;

    // R8: result registers hold while enrN high
    runOp(16'd2, 16'd2, 0, 0, 0, 1);
    enrN = 1; aIn = 16'd6; enaN = 0;
    @(posedge clk); @(negedge clk); enaN = 1;
    @(posedge clk); @(negedge clk);
    checkOut("R8 hold", refFmt(16'd2, 16'd2, 0, 0, 0, 1));
    enrN = 0;
    @(posedge clk); @(negedge clk);
    checkOut("R8 reload", refFmt(16'd6, 16'd2, 0, 0, 0, 1));

    // R8: two-edge latency
    aIn = 16'd11; enaN = 0;
    @(posedge clk); @(negedge clk); enaN = 1;
    checkOut("R8 one edge old", refFmt(16'd6, 16'd2, 0, 0, 0, 1));
    @(posedge clk); @(negedge clk);
    checkOut("R8 two edges new", refFmt(16'd11, 16'd2, 0, 0, 0, 1));

    // R9: pass-through shows product after one edge and follows rsIn
    ftIn = 1; aIn = 16'd13; enaN = 0;
    @(posedge clk); @(negedge clk); enaN = 1;
    checkOut("R9 ft one edge", refFmt(16'd13, 16'd2, 0, 0, 0, 1));
    rsIn = 0; #1;
    checkOut("R9 ft comb rs", refFmt(16'd13, 16'd2, 0, 0, 0, 0));
    rsIn = 1;
    @(posedge clk); @(negedge clk);
    // R9: enrN high shows held register even with ftIn high
    enrN = 1; aIn = 16'd15; enaN = 0;
    @(posedge clk); @(negedge clk); enaN = 1;
    checkOut("R9 ft held", refFmt(16'd13, 16'd2, 0, 0, 0, 1));
    enrN = 0; ftIn = 0;
    @(posedge clk); @(negedge clk);

    // R11: negative result drives msb pair
    runOp(16'hFFFE, 16'd3, 1, 1, 0, 1);
    checkOut("R11 negative", refFmt(16'hFFFE, 16'd3, 1, 1, 0, 1));

    // R12: port release
    runOp(16'd13, 16'd2, 0, 0, 0, 1);
    oeLoN = 1; #1;
    checkReleased("R12 yLo off", yLo, 16'd26);
    oeLoN = 0; selLo = 1; oeHiN = 1; #1;
    checkReleased("R12 yHi off", yHi, 16'd26);
    oeHiN = 0; #1;
    check("R12 yHi on", {16'd0, yHi}, {16'd0, 16'd26});
    selLo = 0;

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule